// File: doc/BRIEF.md
# Eight-Channel Bit-Angle Modulation Generator

This block drives a group of output channels from 8-bit brightness values using bit-angle modulation. It does not compare a counter with every channel value. It keeps the values turned on their side as bit planes. Plane k holds bit k of every channel, so the whole output word for one time slot is a single stored word. A sequencer walks the planes from the least significant weight to the most significant. It keeps each plane on the outputs for a number of ticks equal to that plane's binary weight. Every channel therefore gets a duty cycle proportional to its value over a 255-tick frame.

Ticks come from a single enable strobe, and all sequencing state is frozen on clocks where the strobe is low. The sequencer does not decode the weight from the position. It keeps a one-hot weight register beside the position index, shifts it left on each advance and reloads a slot down-counter from it. A host changes a channel's value over a valid/ready write port. The port never applies back-pressure: `wr_ready` is always high, and every clock with `wr_valid` high commits one write. The new bits are shown on the outputs from the very edge that accepts the write. An update therefore never has to wait up to 127 ticks for the long slot to end.

Top module: `bam_gen`

## Requirements
- R1: After synchronous reset, every plane holds zero, all outputs are low, the sequencer is at position 0 with weight 1, and its slot counter holds 1, so the first tick ends the first slot.
- R2: In every cycle, output bit c equals bit p of channel c's stored value, where p is the current position. All channels switch together.
- R3: Positions run 0,1,...,7 in that order, and position p stays on the outputs for exactly 2^p ticks. The weight register doubles and the position increments on each advance.
- R4: When the slot at position 7 (weight 128) ends, the sequencer returns to position 0 with weight 1, giving a frame of 255 ticks.
- R5: On a clock where `tick_en` is low, the position, weight and slot counter do not change, and without a write the outputs do not change.
- R6: A write of value V to channel c (`wr_chan` = c, a 3-bit index) replaces bit c in all eight planes. From the accepting edge on, output bit c shows bit p of V at the current position p, in the middle of a slot as well.
- R7: A write to one channel leaves every other channel's stored bits and outputs unchanged.
- R8: When a write and a slot advance fall on the same clock, both take effect: after that edge the outputs show the new position's plane, including the newly written bit.
- R9: `wr_ready` is high in every cycle after reset, so each clock with `wr_valid` high commits exactly one write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Tick strobe; the sequencer advances one tick on each clock it is high |
| wr_valid | input | 1 | Write request valid |
| wr_ready | output | 1 | Write request ready (always high) |
| wr_chan | input | 3 | Channel index of the write |
| wr_value | input | 8 | New 8-bit brightness value for the channel |
| chan_out | output | 8 | Modulated channel outputs, bit c drives channel c |

## Verification
The assertions assume that `rst` is held for more than one clock at start-up, and that `wr_chan` always names an existing channel. With eight channels every 3-bit index is legal. They also assume that `tick_en` and the write inputs are stable around the rising edge. The bench drives all inputs on the falling edge and holds reset for several cycles. It uses only channel indices 0 to 7. It mixes dense ticking, sparse ticking and long idle stretches. It times some writes to land on the last tick of a slot, and some in the middle of the 128-tick slot.

// File: rtl/bam_pkg.sv
package bam_pkg;

  // Default geometry of the generator.
  localparam int unsigned BAM_CH_DEFAULT   = 8;
  localparam int unsigned BAM_BITS_DEFAULT = 8;

  // What the sequencer does on a given clock.
  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,  // no tick: freeze
    SEQ_COUNT = 2'd1,  // tick inside a slot: count down
    SEQ_STEP  = 2'd2,  // tick ends a slot: next weight
    SEQ_WRAP  = 2'd3   // tick ends the heaviest slot: restart frame
  } seq_act_e;

endpackage

// File: rtl/bam_planes.sv
module bam_planes #(
  parameter int unsigned CH    = 8,
  parameter int unsigned BITS  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_ch,
  input  logic [BITS-1:0]           wr_val,
  output logic [BITS-1:0][CH-1:0]   planes_o
);

  logic [BITS-1:0][CH-1:0] planes_q;

  // One storage bit per (plane, channel). A write scatters the value's
  // bits across every plane, in the column of the addressed channel.
  for (genvar p = 0; p < BITS; p++) begin : g_plane
    for (genvar c = 0; c < CH; c++) begin : g_chan
      logic hit;
      assign hit = wr_en && (wr_ch == IDX_W'(c));
      always_ff @(posedge clk) begin
        if (rst) begin
          planes_q[p][c] <= 1'b0;
        end else if (hit) begin
          planes_q[p][c] <= wr_val[p];
        end
      end
    end
  end

  assign planes_o = planes_q;

endmodule

// File: rtl/bam_seq.sv
module bam_seq
  import bam_pkg::*;
#(
  parameter int unsigned BITS  = 8,
  parameter int unsigned POS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  output logic [POS_W-1:0] pos_o,
  output logic [BITS-1:0]  weight_o,
  output logic [BITS-1:0]  cnt_o
);

  localparam logic [BITS-1:0]  W_FIRST = BITS'(1);
  localparam logic [POS_W-1:0] P_FIRST = '0;

  logic [POS_W-1:0] pos_q;
  logic [BITS-1:0]  weight_q;
  logic [BITS-1:0]  cnt_q;
  seq_act_e         act;

  logic             slot_done;
  logic             last_plane;

  assign slot_done  = (cnt_q == W_FIRST);
  assign last_plane = weight_q[BITS-1];

  always_comb begin
    if (!tick_en) begin
      act = SEQ_HOLD;
    end else if (!slot_done) begin
      act = SEQ_COUNT;
    end else if (last_plane) begin
      act = SEQ_WRAP;
    end else begin
      act = SEQ_STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= P_FIRST;
      weight_q <= W_FIRST;
      cnt_q    <= W_FIRST;
    end else begin
      unique case (act)
        SEQ_HOLD: begin
        end
        SEQ_COUNT: begin
          cnt_q <= cnt_q - 1'b1;
        end
        SEQ_STEP: begin
          pos_q    <= pos_q + 1'b1;
          weight_q <= {weight_q[BITS-2:0], 1'b0};
          cnt_q    <= {weight_q[BITS-2:0], 1'b0};
        end
        SEQ_WRAP: begin
          pos_q    <= P_FIRST;
          weight_q <= W_FIRST;
          cnt_q    <= W_FIRST;
        end
        default: begin
        end
      endcase
    end
  end

  assign pos_o    = pos_q;
  assign weight_o = weight_q;
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/bam_plane_sel.sv
module bam_plane_sel #(
  parameter int unsigned CH    = 8,
  parameter int unsigned BITS  = 8,
  parameter int unsigned POS_W = 3
) (
  input  logic [BITS-1:0][CH-1:0] planes_i,
  input  logic [POS_W-1:0]        pos_i,
  output logic [CH-1:0]           word_o
);

  // The selected plane is the output word, with no per-channel logic.
  always_comb begin
    word_o = '0;
    for (int p = 0; p < BITS; p++) begin
      if (pos_i == POS_W'(p)) begin
        word_o = planes_i[p];
      end
    end
  end

endmodule

// File: rtl/bam_gen.sv
module bam_gen
  import bam_pkg::*;
#(
  parameter int unsigned CH    = BAM_CH_DEFAULT,
  parameter int unsigned BITS  = BAM_BITS_DEFAULT,
  parameter int unsigned IDX_W = (CH > 1) ? $clog2(CH) : 1,
  parameter int unsigned POS_W = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [IDX_W-1:0] wr_chan,
  input  logic [BITS-1:0]  wr_value,
  output logic [CH-1:0]    chan_out
);

  logic [BITS-1:0][CH-1:0] planes;
  logic [POS_W-1:0]        pos_q;
  logic [BITS-1:0]         weight_q;
  logic [BITS-1:0]         cnt_q;
  logic                    wr_fire;

  // The store takes a write on every clock, so there is never back-pressure.
  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  bam_planes #(.CH(CH), .BITS(BITS), .IDX_W(IDX_W)) u_planes (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_fire),
    .wr_ch    (wr_chan),
    .wr_val   (wr_value),
    .planes_o (planes)
  );

  bam_seq #(.BITS(BITS), .POS_W(POS_W)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .pos_o    (pos_q),
    .weight_o (weight_q),
    .cnt_o    (cnt_q)
  );

  // The outputs follow the stored planes directly. A write shows on the
  // pins from its own edge, whatever is left of the current slot.
  bam_plane_sel #(.CH(CH), .BITS(BITS), .POS_W(POS_W)) u_sel (
    .planes_i (planes),
    .pos_i    (pos_q),
    .word_o   (chan_out)
  );

endmodule

// File: rtl/bam_gen_chk.sv
module bam_gen_chk #(
  parameter int unsigned CH    = 8,
  parameter int unsigned BITS  = 8,
  parameter int unsigned IDX_W = 3,
  parameter int unsigned POS_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             tick_en,
  input logic             wr_valid,
  input logic [IDX_W-1:0] wr_chan,
  input logic [BITS-1:0]  wr_value,
  input logic [CH-1:0]    chan_out,
  input logic [POS_W-1:0] pos,
  input logic [BITS-1:0]  weight,
  input logic [BITS-1:0]  cnt
);

  logic             ends_slot;
  logic             wr_mid;
  logic [IDX_W-1:0] wr_ch_d;
  logic             wr_bit_d;

  assign ends_slot = tick_en && (cnt == BITS'(1));

  // Remember a write that lands inside a slot, and the bit it must show.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mid   <= 1'b0;
      wr_ch_d  <= '0;
      wr_bit_d <= 1'b0;
    end else begin
      wr_mid   <= wr_valid && !ends_slot;
      wr_ch_d  <= wr_chan;
      wr_bit_d <= wr_value[pos];
    end
  end

  // R3: the weight is one-hot and matches the position
  a_r3_weight_onehot: assert property (@(posedge clk) disable iff (rst)
    ($countones(weight) == 1) && (weight == (BITS'(1) << pos)));

  // R3: inside a slot a tick only counts down
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !ends_slot) |=> (cnt == ($past(cnt) - 1'b1)) && $stable(pos) && $stable(weight));

  // R3: ending a non-final slot doubles the weight and reloads the counter
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (ends_slot && !weight[BITS-1]) |=>
      (weight == ($past(weight) << 1)) && (cnt == weight) && (pos == ($past(pos) + 1'b1)));

  // R4: the heaviest slot wraps back to position 0, weight 1
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (ends_slot && weight[BITS-1]) |=> (pos == '0) && (weight == BITS'(1)) && (cnt == BITS'(1)));

  // R5: without a tick the sequencer state is frozen
  a_r5_freeze: assert property (@(posedge clk) disable iff (rst)
    !tick_en |=> $stable(pos) && $stable(weight) && $stable(cnt));

  // R5: with neither tick nor write the outputs are frozen
  a_r5_quiet_out: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !wr_valid) |=> $stable(chan_out));

  // R6: a write inside a slot shows on the outputs from the accepting edge
  a_r6_immediate: assert property (@(posedge clk) disable iff (rst)
    wr_mid |-> (chan_out[wr_ch_d] == wr_bit_d));

endmodule

bind bam_gen bam_gen_chk #(.CH(CH), .BITS(BITS), .IDX_W(IDX_W), .POS_W(POS_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick_en  (tick_en),
  .wr_valid (wr_valid),
  .wr_chan  (wr_chan),
  .wr_value (wr_value),
  .chan_out (chan_out),
  .pos      (pos_q),
  .weight   (weight_q),
  .cnt      (cnt_q)
);

// File: tb/sim_bam_gen.sv
module sim_bam_gen;

  logic       clk;
  logic       rst;
  logic       tick_en;
  logic       wr_valid;
  logic       wr_ready;
  logic [2:0] wr_chan;
  logic [7:0] wr_value;
  logic [7:0] chan_out;

  int checks;
  int fails;
  bit done;

  // Reference model: plain integers
  int mval [8];
  int mpos;
  int mrem;

  bam_gen u0 (
    .clk      (clk),
    .rst      (rst),
    .tick_en  (tick_en),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_chan  (wr_chan),
    .wr_value (wr_value),
    .chan_out (chan_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] expect_out();
    logic [7:0] e;
    for (int c = 0; c < 8; c++) e[c] = ((mval[c] >> mpos) & 1) != 0;
    return e;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: chan_out actual %02h expected %02h (pos %0d)", tag, act, exp, mpos);
    end
  endtask

  // Drive one clock of stimulus on the falling edge, advance the model,
  // then compare on the next falling edge.
  task automatic step(input string tag, input bit tk, input bit wv,
                      input int ch, input int val);
    tick_en  = tk;
    wr_valid = wv;
    wr_chan  = 3'(ch);
    wr_value = 8'(val);
    #0;
    if (wv) begin
      checks++;
      if (wr_ready !== 1'b1) begin
        fails++;
        $display("FAIL R9: wr_ready actual %b expected 1", wr_ready);
      end
      mval[ch] = val;
    end
    if (tk) begin
      mrem = mrem - 1;
      if (mrem == 0) begin
        mpos = (mpos + 1) % 8;
        mrem = 1 << mpos;
      end
    end
    @(negedge clk);
    check(tag, chan_out, expect_out());
  endtask

  initial begin
    checks = 0; fails = 0; done = 0;
    rst = 1'b1; tick_en = 0; wr_valid = 0; wr_chan = 0; wr_value = 0;
    for (int c = 0; c < 8; c++) mval[c] = 0;
    mpos = 0; mrem = 1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state; the first tick ends the 1-tick slot
    check("R1 reset outputs", chan_out, 8'h00);
    step("R1 first tick", 1, 1, 0, 8'hff);
    step("R1 idle", 0, 0, 0, 0);

    // R6 R7 R9: load distinct values with the sequencer frozen
    for (int c = 0; c < 8; c++) step("R6/R7 load", 0, 1, c, (c * 37 + 5) & 8'hff);
    step("R5 idle after load", 0, 0, 0, 0);
    for (int i = 0; i < 20; i++) step("R5 freeze", 0, 0, 0, 0);

    // R2 R3 R4: dense ticking over more than two frames
    for (int i = 0; i < 600; i++) step("R2/R3/R4 dense", 1, 0, 0, 0);

    // R5: sparse ticks, one in three clocks
    for (int i = 0; i < 600; i++) step("R5 sparse", (i % 3) == 0, 0, 0, 0);

    // R6: reach position 7, then clear a channel at 0x80 mid-slot
    step("R6 set 0x80", 0, 1, 2, 8'h80);
    while (!(mpos == 7 && mrem < 100)) step("R3 seek msb", 1, 0, 0, 0);
    step("R6 mid-slot clear", 0, 1, 2, 8'h00);
    step("R7 other channel", 1, 1, 5, 8'h80);
    for (int i = 0; i < 5; i++) step("R6 hold", 1, 0, 0, 0);

    // R8: writes coinciding with a slot advance, several positions
    for (int k = 0; k < 10; k++) begin
      while (mrem != 1) step("R3 seek edge", 1, 0, 0, 0);
      step("R8 write on advance", 1, 1, k % 8, (k * 91 + 1) & 8'hff);
    end

    // R4: mixed writes and ticks across further wraps
    for (int i = 0; i < 700; i++)
      step("R4/R6 mixed", 1, (i % 17) == 0, (i / 17) % 8, (i * 13) & 8'hff);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule